// File: doc/BRIEF.md
# DMA Address Translation Unit

This unit sits between DMA-capable devices and system memory. It turns a 32-bit device address into a physical address. When translation is off, the address passes through unchanged. When translation is on, the unit computes the position of one table entry from a base register and from a slice of the device address. It fetches that 64-bit entry through a memory read port and decodes it into a physical page frame, a page mask and an access permission. If the entry is invalid, or the table geometry is not supported, the result is a fault.

Software sets up the unit through a small register window. It holds a control word, a table base and a flush location. Each register can be reached as one 64-bit word or as two 32-bit halves. Devices present one request at a time on a valid/ready handshake. The unit holds the request until the table read returns, then gives a one-cycle response.

Top module: `iova_xlate`

## Requirements
- R1: After reset the control and base registers read 0, `xl_ready_o` is 1, and `mem_req_o` and `rsp_valid_o` are 0.
- R2: Register offsets are 0x00 for control and 0x08 for base. A 64-bit access at the register offset reaches the whole word. A 32-bit access at that offset reaches bits 63:32. A 32-bit access at offset +4 reaches bits 31:0. Narrow data travels in bits 31:0 and narrow reads are zero-extended. A narrow write leaves the other half unchanged.
- R3: Offsets 0x10 and 0x14 (flush) and every other offset read as 0, and writes to them change no register.
- R4: With control bit 0 clear, a request issues no memory read. The response comes in the cycle after acceptance, with address equal to the input, mask 0x1FFF, permission read-write (2'b11) and no fault.
- R5: With control bit 0 set and control bit 2 clear (8K table pages), the table read address is base + (addr[22+c:13] << 3), where c is control bits 18:16.
- R6: With control bits 0 and 2 set (64K table pages), the table read address is base + (addr[25+c:16] << 3). For c = 6 or 7 no memory read is made and the response is a fault.
- R7: `mem_rdata_i` bits 7:0 hold the byte at the lowest address, which is the most significant byte of the big-endian entry.
- R8: An entry whose bit 63 is clear gives a fault with permission 2'b00, address 0 and mask 0.
- R9: A valid entry with bit 1 set gives permission 2'b11 (read-write). With bit 1 clear it gives 2'b01 (read-only).
- R10: If valid entry bit 61 is set, the mask is 0xFFFF; otherwise it is 0x1FFF. The output address is (entry[40:0] & ~mask) | (addr & mask).
- R11: `xl_ready_o` is low from acceptance until after the response. `mem_req_o` and `mem_addr_o` hold until `mem_rvalid_i`. Each translation makes at most one table read. `rsp_valid_o` is high for exactly one cycle.
- R12: A request accepted in the same cycle as a register write is translated with the register values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_wide_i | input | 1 | 1 = 64-bit access, 0 = 32-bit |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Read data, combinational |
| xl_valid_i | input | 1 | Translation request valid |
| xl_ready_o | output | 1 | Unit can accept a request |
| xl_addr_i | input | 32 | Device address |
| rsp_valid_o | output | 1 | Response valid, one cycle |
| rsp_paddr_o | output | 41 | Translated address |
| rsp_mask_o | output | 16 | Page offset mask |
| rsp_perm_o | output | 2 | 00 none, 01 read-only, 11 read-write |
| rsp_fault_o | output | 1 | Translation fault |
| mem_req_o | output | 1 | Table read request |
| mem_addr_o | output | 64 | Table entry address |
| mem_rvalid_i | input | 1 | Table read data valid |
| mem_rdata_i | input | 64 | Table entry, lowest-addressed byte in bits 7:0 |

## Verification
A register write and a request acceptance can fall on the same clock edge. In that case the control word changes at the moment the geometry of the request is decided. The bench provokes this by raising a request and a 64-bit write that clears the enable bit in the same cycle. It then judges the result on the ports. The table read must still appear at the address computed from the old control word, and the next request must take the pass-through path. The sweeps also cover every table size code in both table page sizes, several memory latencies, both entry page sizes and both permissions.

// File: rtl/iova_pkg.sv
package iova_pkg;
  localparam int unsigned TTE_W        = 64;
  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_T64_BIT = 2;
  localparam int unsigned CTRL_SZ_LSB  = 16;
  localparam int unsigned CTRL_SZ_W    = 3;
  localparam int unsigned MAX_T64_CODE = 5;
  localparam int unsigned LO_BIT_8K    = 13;
  localparam int unsigned LO_BIT_64K   = 16;
  localparam int unsigned HI_BASE_8K   = 22;
  localparam int unsigned HI_BASE_64K  = 25;
  localparam int unsigned ENT_SH       = 3;
  localparam int unsigned TTE_V_BIT    = 63;
  localparam int unsigned TTE_BIG_BIT  = 61;
  localparam int unsigned TTE_WR_BIT   = 1;
  localparam int unsigned PG_SH_8K     = 13;
  localparam int unsigned PG_SH_64K    = 16;

  typedef enum logic [1:0] {
    PERM_NONE = 2'b00,
    PERM_RO   = 2'b01,
    PERM_RW   = 2'b11
  } perm_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEM  = 2'd1,
    ST_RESP = 2'd2
  } state_e;
endpackage

// File: rtl/iova_regs.sv
module iova_regs #(
  parameter int unsigned REG_AW = 5,
  parameter int unsigned DW     = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic              reg_wide_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic [DW-1:0]     ctrl_o,
  output logic [DW-1:0]     base_o
);
  localparam int unsigned HW = DW / 2;

  logic [DW-1:0] ctrl_q, base_q;
  logic          sel_ctrl, sel_base, half_lo, wr;

  assign sel_ctrl = (reg_addr_i[REG_AW-1:3] == '0);
  assign sel_base = (reg_addr_i[REG_AW-1:3] == 1);
  assign half_lo  = reg_addr_i[2];
  assign wr       = reg_req_i && reg_we_i;

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_v,
                                          input logic [DW-1:0] wd,
                                          input logic wide, input logic lo);
    if (lo)        return {old_v[DW-1:HW], wd[HW-1:0]};
    else if (wide) return wd;
    else           return {wd[HW-1:0], old_v[HW-1:0]};
  endfunction

  function automatic logic [DW-1:0] pick(input logic [DW-1:0] v,
                                         input logic wide, input logic lo);
    if (lo)        return {{HW{1'b0}}, v[HW-1:0]};
    else if (wide) return v;
    else           return {{HW{1'b0}}, v[DW-1:HW]};
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      base_q <= '0;
    end else if (wr) begin
      if (sel_ctrl) ctrl_q <= merge(ctrl_q, reg_wdata_i, reg_wide_i, half_lo);
      if (sel_base) base_q <= merge(base_q, reg_wdata_i, reg_wide_i, half_lo);
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_req_i && !reg_we_i) begin
      if (sel_ctrl)      reg_rdata_o = pick(ctrl_q, reg_wide_i, half_lo);
      else if (sel_base) reg_rdata_o = pick(base_q, reg_wide_i, half_lo);
    end
  end

  assign ctrl_o = ctrl_q;
  assign base_o = base_q;

  // R2
  wide_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && reg_wide_i && reg_addr_i == '0) |=> ctrl_q == $past(reg_wdata_i));
  // R2
  narrow_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && !reg_wide_i && reg_addr_i == 5'h08) |=> base_q[HW-1:0] == $past(base_q[HW-1:0]));
  // R3
  flush_ign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && !sel_ctrl && !sel_base) |=> ($stable(ctrl_q) && $stable(base_q)));
endmodule

// File: rtl/iova_index.sv
module iova_index
  import iova_pkg::*;
#(
  parameter int unsigned DEV_AW = 32
) (
  input  logic [TTE_W-1:0]  ctrl_i,
  input  logic [TTE_W-1:0]  base_i,
  input  logic [DEV_AW-1:0] addr_i,
  output logic [TTE_W-1:0]  tbl_addr_o,
  output logic              bad_code_o
);
  logic [CTRL_SZ_W-1:0] code;
  logic                 t64;
  logic [DEV_AW-1:0]    keep, sel;
  int unsigned          lo_b, hi_b;

  always_comb begin
    code = ctrl_i[CTRL_SZ_LSB +: CTRL_SZ_W];
    t64  = ctrl_i[CTRL_T64_BIT];
    lo_b = t64 ? LO_BIT_64K : LO_BIT_8K;
    hi_b = (t64 ? HI_BASE_64K : HI_BASE_8K) + int'(code);
    for (int b = 0; b < DEV_AW; b++) keep[b] = (b >= lo_b) && (b <= hi_b);
    sel        = addr_i & keep;
    tbl_addr_o = base_i + (TTE_W'(sel >> lo_b) << ENT_SH);
    bad_code_o = t64 && (int'(code) > MAX_T64_CODE);
  end
endmodule

// File: rtl/iova_entry.sv
module iova_entry
  import iova_pkg::*;
#(
  parameter int unsigned DEV_AW  = 32,
  parameter int unsigned PHYS_AW = 41,
  parameter int unsigned MASK_W  = 16
) (
  input  logic [TTE_W-1:0]   rdata_i,
  input  logic [DEV_AW-1:0]  addr_i,
  output logic [PHYS_AW-1:0] paddr_o,
  output logic [MASK_W-1:0]  mask_o,
  output perm_e              perm_o,
  output logic               fault_o
);
  localparam int unsigned NBYTES = TTE_W / 8;

  logic [TTE_W-1:0]   tte;
  logic [PHYS_AW-1:0] m;

  // big-endian: lowest-addressed byte is the entry's top byte
  for (genvar g = 0; g < NBYTES; g++) begin : g_swap
    assign tte[TTE_W-1-8*g -: 8] = rdata_i[8*g +: 8];
  end

  always_comb begin
    mask_o  = tte[TTE_BIG_BIT] ? MASK_W'((1 << PG_SH_64K) - 1)
                               : MASK_W'((1 << PG_SH_8K) - 1);
    m       = PHYS_AW'(mask_o);
    paddr_o = (tte[PHYS_AW-1:0] & ~m) | (PHYS_AW'(addr_i) & m);
    perm_o  = tte[TTE_WR_BIT] ? PERM_RW : PERM_RO;
    fault_o = 1'b0;
    if (!tte[TTE_V_BIT]) begin
      mask_o  = '0;
      paddr_o = '0;
      perm_o  = PERM_NONE;
      fault_o = 1'b1;
    end
  end
endmodule

// File: rtl/iova_xlate.sv
module iova_xlate
  import iova_pkg::*;
#(
  parameter int unsigned DEV_AW  = 32,
  parameter int unsigned PHYS_AW = 41,
  parameter int unsigned MASK_W  = 16,
  parameter int unsigned REG_AW  = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_req_i,
  input  logic               reg_we_i,
  input  logic               reg_wide_i,
  input  logic [REG_AW-1:0]  reg_addr_i,
  input  logic [63:0]        reg_wdata_i,
  output logic [63:0]        reg_rdata_o,
  input  logic               xl_valid_i,
  output logic               xl_ready_o,
  input  logic [DEV_AW-1:0]  xl_addr_i,
  output logic               rsp_valid_o,
  output logic [PHYS_AW-1:0] rsp_paddr_o,
  output logic [MASK_W-1:0]  rsp_mask_o,
  output logic [1:0]         rsp_perm_o,
  output logic               rsp_fault_o,
  output logic               mem_req_o,
  output logic [63:0]        mem_addr_o,
  input  logic               mem_rvalid_i,
  input  logic [63:0]        mem_rdata_i
);
  localparam logic [MASK_W-1:0] PASS_MASK = MASK_W'((1 << PG_SH_8K) - 1);

  logic [TTE_W-1:0]   ctrl, base, tbl_addr;
  logic               bad_code, accept, xl_en;
  logic [PHYS_AW-1:0] ent_paddr;
  logic [MASK_W-1:0]  ent_mask;
  perm_e              ent_perm;
  logic               ent_fault;

  state_e             state_q;
  logic [DEV_AW-1:0]  addr_q;
  logic [TTE_W-1:0]   mem_addr_q;
  logic [PHYS_AW-1:0] paddr_q;
  logic [MASK_W-1:0]  mask_q;
  perm_e              perm_q;
  logic               fault_q;

  iova_regs #(.REG_AW(REG_AW), .DW(TTE_W)) i_regs (
    .clk_i, .rst_ni, .reg_req_i, .reg_we_i, .reg_wide_i, .reg_addr_i,
    .reg_wdata_i, .reg_rdata_o, .ctrl_o(ctrl), .base_o(base)
  );

  iova_index #(.DEV_AW(DEV_AW)) i_index (
    .ctrl_i(ctrl), .base_i(base), .addr_i(xl_addr_i),
    .tbl_addr_o(tbl_addr), .bad_code_o(bad_code)
  );

  iova_entry #(.DEV_AW(DEV_AW), .PHYS_AW(PHYS_AW), .MASK_W(MASK_W)) i_entry (
    .rdata_i(mem_rdata_i), .addr_i(addr_q), .paddr_o(ent_paddr),
    .mask_o(ent_mask), .perm_o(ent_perm), .fault_o(ent_fault)
  );

  assign xl_en  = ctrl[CTRL_EN_BIT];
  assign accept = xl_valid_i && (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      mem_addr_q <= '0;
      paddr_q    <= '0;
      mask_q     <= '0;
      perm_q     <= PERM_NONE;
      fault_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          addr_q <= xl_addr_i;
          if (!xl_en) begin
            paddr_q <= PHYS_AW'(xl_addr_i);
            mask_q  <= PASS_MASK;
            perm_q  <= PERM_RW;
            fault_q <= 1'b0;
            state_q <= ST_RESP;
          end else if (bad_code) begin
            paddr_q <= '0;
            mask_q  <= '0;
            perm_q  <= PERM_NONE;
            fault_q <= 1'b1;
            state_q <= ST_RESP;
          end else begin
            mem_addr_q <= tbl_addr;
            state_q    <= ST_MEM;
          end
        end
        ST_MEM: if (mem_rvalid_i) begin
          paddr_q <= ent_paddr;
          mask_q  <= ent_mask;
          perm_q  <= ent_perm;
          fault_q <= ent_fault;
          state_q <= ST_RESP;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign xl_ready_o  = (state_q == ST_IDLE);
  assign mem_req_o   = (state_q == ST_MEM);
  assign mem_addr_o  = mem_addr_q;
  assign rsp_valid_o = (state_q == ST_RESP);
  assign rsp_paddr_o = paddr_q;
  assign rsp_mask_o  = mask_q;
  assign rsp_perm_o  = perm_q;
  assign rsp_fault_o = fault_q;

  // R11
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));
  // R11
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  // R11
  busy_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o || rsp_valid_o) |-> !xl_ready_o);
  // R4
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xl_valid_i && xl_ready_o && !xl_en) |=>
      (rsp_valid_o && !mem_req_o && rsp_perm_o == PERM_RW && !rsp_fault_o));
  // R6
  bad_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && xl_en && bad_code) |=> (rsp_valid_o && rsp_fault_o && !mem_req_o));
  // R8
  fault_perm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o) |-> (rsp_perm_o == PERM_NONE && rsp_mask_o == '0));
endmodule

// File: tb/test_iova_xlate.sv
module test_iova_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_req = 1'b0, reg_we = 1'b0, reg_wide = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        xl_valid = 1'b0;
  logic        xl_ready;
  logic [31:0] xl_addr = '0;
  logic        rsp_valid;
  logic [40:0] rsp_paddr;
  logic [15:0] rsp_mask;
  logic [1:0]  rsp_perm;
  logic        rsp_fault;
  logic        mem_req;
  logic [63:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  logic [63:0] cur_ctrl = '0;
  logic [63:0] cur_base = '0;

  always #10 clk = ~clk;

  iova_xlate i_iova_xlate (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_req_i(reg_req), .reg_we_i(reg_we), .reg_wide_i(reg_wide),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .xl_valid_i(xl_valid), .xl_ready_o(xl_ready), .xl_addr_i(xl_addr),
    .rsp_valid_o(rsp_valid), .rsp_paddr_o(rsp_paddr), .rsp_mask_o(rsp_mask),
    .rsp_perm_o(rsp_perm), .rsp_fault_o(rsp_fault),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input bit wide, input logic [63:0] d);
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_wide = wide; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_req = 0; reg_we = 0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input bit wide, input logic [63:0] exp, input string tag);
    @(negedge clk);
    reg_req = 1; reg_we = 0; reg_wide = wide; reg_addr = a;
    #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
    reg_req = 0;
  endtask

  function automatic logic [63:0] to_bus(input logic [63:0] tte);
    logic [63:0] b;
    for (int i = 0; i < 8; i++) b[8*i +: 8] = tte[63-8*i -: 8];
    return b;
  endfunction

  // bench model
  logic        m_mem;
  logic [63:0] m_maddr;
  logic [40:0] m_pa;
  logic [15:0] m_mk;
  logic [1:0]  m_pm;
  logic        m_flt;

  task automatic model(input logic [63:0] ctrl, input logic [63:0] base,
                       input logic [31:0] a, input logic [63:0] tte);
    int unsigned code;
    logic [63:0] span, pg, frame;
    code = ctrl[18:16];
    m_mem = 0; m_maddr = '0; m_pa = '0; m_mk = '0; m_pm = 2'b00; m_flt = 1;
    if (!ctrl[0]) begin
      m_pa = 41'(a); m_mk = 16'h1FFF; m_pm = 2'b11; m_flt = 0;
      return;
    end
    if (ctrl[2]) begin
      if (code > 5) return;
      span = 64'd1 << (26 + code);
      m_maddr = base + (((64'(a) % span) >> 16) << 3);
    end else begin
      span = 64'd1 << (23 + code);
      m_maddr = base + (((64'(a) % span) >> 13) << 3);
    end
    m_mem = 1;
    if (!tte[63]) return;
    m_flt = 0;
    m_pm  = tte[1] ? 2'b11 : 2'b01;
    pg    = tte[61] ? 64'd65536 : 64'd8192;
    frame = (64'(tte[40:0]) / pg) * pg;
    m_pa  = 41'(frame + (64'(a) % pg));
    m_mk  = 16'(pg - 1);
  endtask

  task automatic finish_xlate(input logic [63:0] tte, input int dly, input string tag);
    if (m_mem) begin
      chk(mem_req == 1'b1 && rsp_valid == 1'b0, {tag, " R11 read issued"}, 64'(mem_req), 64'd1);
      chk(mem_addr == m_maddr, {tag, " table address"}, mem_addr, m_maddr);
      chk(xl_ready == 1'b0, {tag, " R11 ready low"}, 64'(xl_ready), 64'd0);
      for (int i = 0; i < dly; i++) begin
        @(negedge clk);
        chk(mem_req == 1'b1 && mem_addr == m_maddr, {tag, " R11 hold"}, mem_addr, m_maddr);
      end
      mem_rvalid = 1; mem_rdata = to_bus(tte);
      @(negedge clk);
      mem_rvalid = 0; mem_rdata = '0;
    end else begin
      chk(mem_req == 1'b0, {tag, " no read"}, 64'(mem_req), 64'd0);
    end
    chk(rsp_valid == 1'b1, {tag, " R11 resp valid"}, 64'(rsp_valid), 64'd1);
    chk(rsp_fault == m_flt, {tag, " fault"}, 64'(rsp_fault), 64'(m_flt));
    chk(rsp_perm == m_pm, {tag, " R9 perm"}, 64'(rsp_perm), 64'(m_pm));
    chk(rsp_mask == m_mk, {tag, " R10 mask"}, 64'(rsp_mask), 64'(m_mk));
    chk(rsp_paddr == m_pa, {tag, " R10 paddr"}, 64'(rsp_paddr), 64'(m_pa));
    @(negedge clk);
    chk(rsp_valid == 1'b0 && mem_req == 1'b0, {tag, " R11 pulse"}, 64'(rsp_valid), 64'd0);
    chk(xl_ready == 1'b1, {tag, " R11 ready back"}, 64'(xl_ready), 64'd1);
  endtask

  task automatic xlate(input logic [31:0] a, input logic [63:0] tte, input int dly, input string tag);
    model(cur_ctrl, cur_base, a, tte);
    @(negedge clk);
    chk(xl_ready == 1'b1, {tag, " R11 idle ready"}, 64'(xl_ready), 64'd1);
    xl_valid = 1; xl_addr = a;
    @(negedge clk);
    xl_valid = 0;
    finish_xlate(tte, dly, tag);
  endtask

  task automatic set_ctrl(input logic [63:0] v);
    wr(5'h00, 1, v);
    cur_ctrl = v;
  endtask

  logic [31:0] addrs [4];
  logic [63:0] tte;

  initial begin
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=done", checks);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    addrs[0] = 32'hFFFF_FFFF; addrs[1] = 32'h8765_4321;
    addrs[2] = 32'h0000_2000; addrs[3] = 32'h5A5A_A5A5;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1
    chk(xl_ready == 1 && mem_req == 0 && rsp_valid == 0, "R1 reset outputs",
        {61'd0, xl_ready, mem_req, rsp_valid}, 64'd4);
    rd_chk(5'h00, 1, 64'd0, "R1 ctrl reset");
    rd_chk(5'h08, 1, 64'd0, "R1 base reset");

    // R2 register halves
    wr(5'h08, 1, 64'h1122_3344_5566_7788);
    rd_chk(5'h08, 1, 64'h1122_3344_5566_7788, "R2 wide base");
    rd_chk(5'h08, 0, 64'h1122_3344, "R2 upper half");
    rd_chk(5'h0C, 0, 64'h5566_7788, "R2 lower half");
    wr(5'h08, 0, 64'hAABB_CCDD);
    rd_chk(5'h08, 1, 64'hAABB_CCDD_5566_7788, "R2 narrow upper write");
    wr(5'h0C, 0, 64'h0102_0304);
    rd_chk(5'h08, 1, 64'hAABB_CCDD_0102_0304, "R2 narrow lower write");
    wr(5'h04, 0, 64'h0000_0000);
    wr(5'h00, 0, 64'h0000_0000);
    rd_chk(5'h00, 1, 64'd0, "R2 ctrl halves");

    // R3 flush and unmapped
    wr(5'h10, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(5'h14, 0, 64'hFFFF_FFFF);
    wr(5'h18, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_chk(5'h10, 1, 64'd0, "R3 flush reads 0");
    rd_chk(5'h14, 0, 64'd0, "R3 flush low reads 0");
    rd_chk(5'h18, 1, 64'd0, "R3 unmapped reads 0");
    rd_chk(5'h08, 1, 64'hAABB_CCDD_0102_0304, "R3 base untouched");
    rd_chk(5'h00, 1, 64'd0, "R3 ctrl untouched");

    // R4 pass-through
    cur_base = 64'h0000_0012_3400_0000;
    wr(5'h08, 1, cur_base);
    for (int i = 0; i < 8; i++)
      xlate(32'h9E37_79B9 * (i + 1), 64'd0, 0, "R4 bypass");

    // R5 8K table pages, all size codes
    for (int c = 0; c < 8; c++) begin
      set_ctrl(64'h1 | (64'(c) << 16));
      for (int k = 0; k < 4; k++) begin
        tte = 64'h0000_0155_5555_5555 ^ (64'(c * 4 + k) << 20);
        tte[63] = 1; tte[61] = k[0]; tte[1] = k[1];
        xlate(addrs[k], tte, (c + k) % 4, "R5 8K table");
      end
    end

    // R6 64K table pages, all size codes (6, 7 fault)
    for (int c = 0; c < 8; c++) begin
      set_ctrl(64'h5 | (64'(c) << 16));
      for (int k = 0; k < 4; k++) begin
        tte = 64'h0000_00AA_AAAA_AAAA ^ (64'(c * 4 + k) << 17);
        tte[63] = 1; tte[61] = k[1]; tte[1] = k[0];
        xlate(addrs[k], tte, k, "R6 64K table");
      end
    end

    // R8 invalid entries
    set_ctrl(64'h1 | (64'd3 << 16));
    for (int k = 0; k < 4; k++)
      xlate(addrs[k], 64'h7FFF_FFFF_FFFF_FFFF ^ (64'(k) << 30), 1, "R8 invalid entry");

    // R7 byte order with distinct bytes
    xlate(32'h0123_4567, 64'hA000_0123_4567_89AB, 2, "R7 byte order");
    xlate(32'h0123_4567, 64'h8000_01FE_DCBA_9876, 0, "R7 byte order");

    // R12 write clearing enable in the acceptance cycle
    set_ctrl(64'h1);
    tte = 64'h8000_0100_0000_2002;
    model(cur_ctrl, cur_base, 32'h00AB_CDEF, tte);
    @(negedge clk);
    xl_valid = 1; xl_addr = 32'h00AB_CDEF;
    reg_req = 1; reg_we = 1; reg_wide = 1; reg_addr = 5'h00; reg_wdata = 64'd0;
    @(negedge clk);
    xl_valid = 0; reg_req = 0; reg_we = 0;
    finish_xlate(tte, 1, "R12 old control used");
    cur_ctrl = 64'd0;
    xlate(32'h00AB_CDEF, tte, 0, "R12 new control after");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule